// File: doc/BRIEF.md
# Drive PIO Timing to Bus-Clock Converter

This block turns the three timing figures of a programmed-I/O drive transfer into bus-clock counts for an interface controller running at a known bus frequency. The three figures are the address setup, the active data pulse and the whole cycle, all in nanoseconds. Each count is rounded up so the drive never gets less time than it asks for. The recovery period is whatever the cycle leaves after setup and the active pulse. Each count is then forced into the range the timing hardware can represent.

The data and recovery counts are also packed into one cycle-timing byte, ready to write into a per-drive timing register. When a drive slot is empty, the block emits fixed minimal counts instead. A request is presented with `valid_in`. The result appears one clock later with `valid_out`, and it holds until the next request.

Top module: `pio_clk_conv`

## Requirements
- R1: The address and data counts are computed before clamping as ceil(t_ns × f_MHz / 1000), that is (t·f + 999) / 1000 in integer arithmetic. An exact multiple is not rounded up (40 ns at 25 MHz gives 1).
- R2: The recovery count uses the same rounding on (cycle − setup − active) ns. When setup + active is at least the cycle time, the recovery time is taken as 0 ns.
- R3: The address count `addr_clk` is clamped to the range 1 to 4.
- R4: The data count `data_clk` is clamped to 1 to 16, and the recovery count `rec_clk` is clamped to 2 to 17.
- R5: When `absent` is 1 on a request, the outputs are address 1, data 1 and recovery 2, whatever the timing inputs are.
- R6: `cycle_byte` bits 7:4 hold (data_clk − 1) and bits 3:0 hold (rec_clk − 2).
- R7: The internal products are wide enough for the largest inputs: 1023 ns at 127 MHz gives 130 clocks before clamping, so the data count is 16.
- R8: `valid_out` is 1 exactly one clock after a cycle with `valid_in` = 1. The result outputs are registered and update with that clock edge.
- R9: While `valid_in` is 0, all result outputs hold their last value, whatever the timing inputs do.
- R10: After reset, `valid_out` is 0, `addr_clk` is 1, `data_clk` is 1, `rec_clk` is 2 and `cycle_byte` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Request strobe |
| setup_ns | input | 10 | Address setup time, ns |
| active_ns | input | 10 | Active pulse time, ns |
| cycle_ns | input | 10 | Total cycle time, ns |
| bus_mhz | input | 7 | Bus frequency, MHz |
| absent | input | 1 | Drive slot empty |
| valid_out | output | 1 | Result strobe, one clock after the request |
| addr_clk | output | 3 | Clamped address-setup clocks |
| data_clk | output | 5 | Clamped data-pulse clocks |
| rec_clk | output | 5 | Clamped recovery clocks |
| cycle_byte | output | 8 | Packed cycle-timing byte |

## Verification
The bench aims at the following corner cases:
- **Exact multiples of the clock period.** A design that rounds these up gives one clock too many.
- **Cycles shorter than setup plus active.** Here a subtraction that wraps would give a huge recovery time, which clamps to 17 instead of 2.
- **The largest time and frequency.** A product that is too narrow would truncate and give a small data count instead of 16.
- **Empty drive slots.** These take the minimal counts, however far the timing inputs are out of range.

Random requests are checked against an integer model. Idle cycles with changing inputs show whether results wrongly follow the inputs while no request is present.

// File: rtl/pio_conv_pkg.sv
package pio_conv_pkg;
  // Output field widths and clamp limits
  localparam int ADR_W   = 3;
  localparam int DAT_W   = 5;
  localparam int REC_W   = 5;
  localparam int NIB_W   = 4;
  localparam int ADR_MIN = 1;
  localparam int ADR_MAX = 4;
  localparam int DAT_MIN = 1;
  localparam int DAT_MAX = 16;
  localparam int REC_MIN = 2;
  localparam int REC_MAX = 17;
  localparam int NS_PER_US = 1000;

  typedef struct packed {
    logic [ADR_W-1:0] addr;
    logic [DAT_W-1:0] data;
    logic [REC_W-1:0] rec;
  } clk_set_t;
endpackage

// File: rtl/ns_ceil_conv.sv
module ns_ceil_conv #(
  parameter int TIN_W = 11,
  parameter int F_W   = 7,
  parameter int DIV   = 1000,
  localparam int PROD_W = TIN_W + F_W,
  localparam int SUM_W  = PROD_W + 1
) (
  input  logic [TIN_W-1:0] t_ns,
  input  logic [F_W-1:0]   f_mhz,
  output logic [SUM_W-1:0] clocks
);
  logic [PROD_W-1:0] prod;
  logic [SUM_W-1:0]  biased;

  always_comb begin
    prod   = PROD_W'(t_ns) * PROD_W'(f_mhz);
    biased = SUM_W'(prod) + SUM_W'(DIV - 1);
    clocks = biased / SUM_W'(DIV);
  end
endmodule

// File: rtl/range_clamp.sv
module range_clamp #(
  parameter int IN_W  = 19,
  parameter int OUT_W = 5,
  parameter int MINV  = 1,
  parameter int MAXV  = 16
) (
  input  logic [IN_W-1:0]  val,
  output logic [OUT_W-1:0] res
);
  always_comb begin
    if (val < IN_W'(MINV))
      res = OUT_W'(MINV);
    else if (val > IN_W'(MAXV))
      res = OUT_W'(MAXV);
    else
      res = val[OUT_W-1:0];
  end
endmodule

// File: rtl/cycle_packer.sv
module cycle_packer
  import pio_conv_pkg::*;
(
  input  logic [DAT_W-1:0]   data,
  input  logic [REC_W-1:0]   rec,
  output logic [2*NIB_W-1:0] packed_byte
);
  logic [NIB_W-1:0] d_nib;
  logic [NIB_W-1:0] r_nib;

  always_comb begin
    d_nib       = NIB_W'(data - DAT_W'(DAT_MIN));
    r_nib       = NIB_W'(rec - REC_W'(REC_MIN));
    packed_byte = {d_nib, r_nib};
  end
endmodule

// File: rtl/pio_clk_conv.sv
module pio_clk_conv
  import pio_conv_pkg::*;
#(
  parameter int T_W = 10,
  parameter int F_W = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid_in,
  input  logic [T_W-1:0] setup_ns,
  input  logic [T_W-1:0] active_ns,
  input  logic [T_W-1:0] cycle_ns,
  input  logic [F_W-1:0] bus_mhz,
  input  logic           absent,
  output logic           valid_out,
  output logic [ADR_W-1:0] addr_clk,
  output logic [DAT_W-1:0] data_clk,
  output logic [REC_W-1:0] rec_clk,
  output logic [2*NIB_W-1:0] cycle_byte
);
  localparam int TIN_W  = T_W + 1;
  localparam int SUM_W  = TIN_W + F_W + 1;
  localparam int NFIELD = 3;

  // Recovery span in ns, saturating at zero
  logic [TIN_W-1:0] busy_ns;
  logic [TIN_W-1:0] rec_ns;
  always_comb begin
    busy_ns = TIN_W'(setup_ns) + TIN_W'(active_ns);
    if (TIN_W'(cycle_ns) > busy_ns)
      rec_ns = TIN_W'(cycle_ns) - busy_ns;
    else
      rec_ns = '0;
  end

  // Field order: 0 address, 1 data, 2 recovery
  logic [TIN_W-1:0] span_ns [NFIELD];
  logic [SUM_W-1:0] raw_clk [NFIELD];
  assign span_ns[0] = TIN_W'(setup_ns);
  assign span_ns[1] = TIN_W'(active_ns);
  assign span_ns[2] = rec_ns;

  for (genvar g = 0; g < NFIELD; g++) begin : g_conv
    ns_ceil_conv #(
      .TIN_W(TIN_W),
      .F_W  (F_W),
      .DIV  (NS_PER_US)
    ) i_conv (
      .t_ns  (span_ns[g]),
      .f_mhz (bus_mhz),
      .clocks(raw_clk[g])
    );
  end

  clk_set_t clamped;
  clk_set_t chosen;

  range_clamp #(.IN_W(SUM_W), .OUT_W(ADR_W), .MINV(ADR_MIN), .MAXV(ADR_MAX))
    i_clamp_adr (.val(raw_clk[0]), .res(clamped.addr));
  range_clamp #(.IN_W(SUM_W), .OUT_W(DAT_W), .MINV(DAT_MIN), .MAXV(DAT_MAX))
    i_clamp_dat (.val(raw_clk[1]), .res(clamped.data));
  range_clamp #(.IN_W(SUM_W), .OUT_W(REC_W), .MINV(REC_MIN), .MAXV(REC_MAX))
    i_clamp_rec (.val(raw_clk[2]), .res(clamped.rec));

  always_comb begin
    if (absent) begin
      chosen.addr = ADR_W'(ADR_MIN);
      chosen.data = DAT_W'(DAT_MIN);
      chosen.rec  = REC_W'(REC_MIN);
    end else begin
      chosen = clamped;
    end
  end

  logic [2*NIB_W-1:0] packed_next;
  cycle_packer i_pack (
    .data       (chosen.data),
    .rec        (chosen.rec),
    .packed_byte(packed_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out  <= 1'b0;
      addr_clk   <= ADR_W'(ADR_MIN);
      data_clk   <= DAT_W'(DAT_MIN);
      rec_clk    <= REC_W'(REC_MIN);
      cycle_byte <= '0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        addr_clk   <= chosen.addr;
        data_clk   <= chosen.data;
        rec_clk    <= chosen.rec;
        cycle_byte <= packed_next;
      end
    end
  end
endmodule

// File: rtl/pio_clk_conv_chk.sv
module pio_clk_conv_chk
  import pio_conv_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic valid_in,
  input logic absent,
  input logic valid_out,
  input logic [ADR_W-1:0] addr_clk,
  input logic [DAT_W-1:0] data_clk,
  input logic [REC_W-1:0] rec_clk,
  input logic [2*NIB_W-1:0] cycle_byte
);
  p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> (addr_clk >= ADR_W'(ADR_MIN) && addr_clk <= ADR_W'(ADR_MAX)));

  p_data_rec_range_r4: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> (data_clk >= DAT_W'(DAT_MIN) && data_clk <= DAT_W'(DAT_MAX) &&
                   rec_clk >= REC_W'(REC_MIN) && rec_clk <= REC_W'(REC_MAX)));

  p_absent_min_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_in && absent) |=> (addr_clk == ADR_W'(ADR_MIN) &&
      data_clk == DAT_W'(DAT_MIN) && rec_clk == REC_W'(REC_MIN)));

  p_pack_r6: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> (cycle_byte[7:4] == NIB_W'(data_clk - DAT_W'(1)) &&
                   cycle_byte[3:0] == NIB_W'(rec_clk - REC_W'(2))));

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);

  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> ($stable(cycle_byte) && $stable(addr_clk)));
endmodule

bind pio_clk_conv pio_clk_conv_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_in  (valid_in),
  .absent    (absent),
  .valid_out (valid_out),
  .addr_clk  (addr_clk),
  .data_clk  (data_clk),
  .rec_clk   (rec_clk),
  .cycle_byte(cycle_byte)
);

// File: tb/test_pio_clk_conv.sv
`timescale 1ns/1ps
module test_pio_clk_conv;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_in = 1'b0;
  logic [9:0] setup_ns = '0, active_ns = '0, cycle_ns = '0;
  logic [6:0] bus_mhz = '0;
  logic absent = 1'b0;
  logic valid_out;
  logic [2:0] addr_clk;
  logic [4:0] data_clk, rec_clk;
  logic [7:0] cycle_byte;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int a; int d; int r; int b; string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  pio_clk_conv i_pio_clk_conv (
    .clk(clk), .rst(rst), .valid_in(valid_in),
    .setup_ns(setup_ns), .active_ns(active_ns), .cycle_ns(cycle_ns),
    .bus_mhz(bus_mhz), .absent(absent), .valid_out(valid_out),
    .addr_clk(addr_clk), .data_clk(data_clk), .rec_clk(rec_clk),
    .cycle_byte(cycle_byte)
  );

  function automatic int ceilc(int t, int f);
    return (t * f + 999) / 1000;
  endfunction

  function automatic int clampv(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic check(string tag, int act, int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  // Driver: applies one request and pushes the model result
  task automatic drive(int s, int a, int c, int f, bit abs_f, string tag);
    exp_t e;
    int rn;
    @(negedge clk);
    setup_ns = 10'(s); active_ns = 10'(a); cycle_ns = 10'(c);
    bus_mhz = 7'(f); absent = abs_f; valid_in = 1'b1;
    rn = (c > s + a) ? (c - s - a) : 0;                 // R2
    if (abs_f) begin                                    // R5
      e.a = 1; e.d = 1; e.r = 2;
    end else begin
      e.a = clampv(ceilc(s, f), 1, 4);                  // R1 R3
      e.d = clampv(ceilc(a, f), 1, 16);                 // R1 R4 R7
      e.r = clampv(ceilc(rn, f), 2, 17);                // R2 R4
    end
    e.b = ((e.d - 1) << 4) | (e.r - 2);                 // R6
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_in = 1'b0;
    end
  endtask

  // Monitor: pops one expected item per result strobe (R8)
  always @(negedge clk) begin
    if (!rst && valid_out) begin
      if (sb.size() == 0) begin
        check("R8 unexpected valid_out", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " addr"}, int'(addr_clk), e.a);
        check({e.tag, " data"}, int'(data_clk), e.d);
        check({e.tag, " rec"}, int'(rec_clk), e.r);
        check({e.tag, " byte R6"}, int'(cycle_byte), e.b);
      end
    end
  end

  initial begin
    int wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      check("watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    exp_t last;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 valid_out", int'(valid_out), 0);
    check("R10 addr", int'(addr_clk), 1);
    check("R10 data", int'(data_clk), 1);
    check("R10 rec", int'(rec_clk), 2);
    check("R10 byte", int'(cycle_byte), 0);

    drive(70, 165, 600, 33, 0, "R1 slow mode 33MHz");
    drive(70, 165, 600, 66, 0, "R3 address clamp 66MHz");
    drive(40, 40, 200, 25, 0, "R1 exact multiple");
    drive(25, 70, 120, 20, 0, "R2 normal recovery");
    drive(300, 300, 400, 33, 0, "R2 negative recovery");
    drive(0, 0, 0, 50, 0, "R4 zero times lower clamps");
    drive(1023, 1023, 1023, 127, 0, "R7 largest inputs");
    drive(30, 600, 1023, 33, 0, "R4 upper clamps");
    drive(1023, 1023, 1023, 127, 1, "R5 absent with large inputs");
    drive(70, 165, 600, 33, 1, "R5 absent normal inputs");
    idle(2);

    // R9: inputs change while idle, outputs must keep last result
    drive(80, 290, 600, 40, 0, "R9 reference");
    last.a = clampv(ceilc(80, 40), 1, 4);
    last.d = clampv(ceilc(290, 40), 1, 16);
    last.r = clampv(ceilc(230, 40), 2, 17);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      valid_in = 1'b0;
      setup_ns = 10'(900 - i); active_ns = 10'(5 + i); cycle_ns = 10'(11);
      bus_mhz = 7'(127); absent = i[0];
    end
    check("R9 hold addr", int'(addr_clk), last.a);
    check("R9 hold data", int'(data_clk), last.d);
    check("R9 hold rec", int'(rec_clk), last.r);
    check("R8 valid_out low when idle", int'(valid_out), 0);

    for (int k = 0; k < 300; k++) begin
      drive(int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
            int'($urandom_range(0, 1023)), int'($urandom_range(1, 127)),
            ($urandom_range(0, 7) == 0), "R1 random");
      if (k % 5 == 4) idle(1);
    end
    idle(3);
    check("R8 scoreboard drained", sb.size(), 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule